// File: doc/BRIEF.md
# Host Byte-Serial Frame Access Port

This block lets a host processor exchange whole frames with a packet datapath through a small register window, one byte per bus access. Frames that the datapath has set aside arrive as a byte stream and are held in an extract store. The host learns that a frame is waiting from a status bit, a sticky event bit or an interrupt. It reads the frame's byte count and pulls the bytes through one data register, starting with the first byte. It then releases the frame with a rising edge on a done bit. In the other direction, the host programs a byte count, writes the bytes through the same data register and commits the frame with a second done bit. The frame then streams out toward the datapath.

A select bit decides whether the shared data, length and done registers act on the extract store or on the insert store. Both stores keep a byte ring and a small queue of frame lengths, so several whole frames can be pending in each direction. The MAC and any encapsulation logic sit outside this block.

Top module: `hfp_host_port`

Register window (3-bit address, 8-bit data; reads return data one clock after the read strobe):
0 SEL (bit0: 0 = extract store, 1 = insert store); 1 STAT (read only: bit0 frame waiting in extract store, bit1 no committed frame in insert store); 2 EVENT (bit0 frame-arrived event, bit1 insert-drop event; writing 1 clears a bit); 3 IRQEN (bit0 enables the frame-arrived interrupt); 4 LEN_LO and 5 LEN_HI (16-bit length, low byte first); 6 DATA; 7 DONE (bit0 release, bit1 commit; each acts on a 0-to-1 change of the stored bit).

## Requirements
- R1: After reset, STAT reads 0x02, SEL reads 0, `irq` is 0, `ext_in_ready` is 1 and `ins_out_valid` is 0.
- R2: With SEL=0 and a frame waiting, LEN_LO/LEN_HI report its byte count and successive DATA reads return its bytes in arrival order, one byte per read.
- R3: A DATA read with SEL=0 returns 0x00 and does not advance the read position when all bytes of the head frame have been read or when no frame is waiting; LEN then reads 0 when no frame is waiting.
- R4: Writing DONE bit0 from 0 to 1 with SEL=0 discards the head extract frame, and the next frame (if any) is presented from its first byte. Writing 1 to a bit that already holds 1 has no effect.
- R5: With SEL=1, DATA reads return 0x00 and leave the extract read position unchanged. With SEL=0, DATA writes and LEN writes are ignored.
- R6: With SEL=1, the host writes LEN_LO/LEN_HI and then the bytes. A 0-to-1 change of DONE bit1 commits the frame when the byte count equals the programmed length. The frame then leaves on `ins_out_*` in write order, with `ins_out_last` on its final byte only.
- R7: Data writes beyond the programmed length are ignored. A commit with fewer bytes written than programmed, or with length 0, drops the frame so that nothing is sent, and it sets EVENT bit1.
- R8: STAT bit0 is 1 exactly while the extract store holds at least one complete frame. STAT bit1 is 1 exactly while no committed insert frame remains to be sent.
- R9: EVENT bit0 is set whenever a complete frame enters the extract store and is cleared by writing 1 to it. `irq` equals EVENT bit0 AND IRQEN bit0.
- R10: `ext_in_ready` is 0 while the extract store holds EXT_DEPTH bytes or EXT_SLOTS frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hwr_en | input | 1 | Host register write strobe |
| hrd_en | input | 1 | Host register read strobe |
| haddr | input | 3 | Host register address |
| hwdata | input | 8 | Host write data |
| hrdata | output | 8 | Host read data, valid the cycle after the read strobe |
| irq | output | 1 | Frame-arrived interrupt |
| ext_in_valid | input | 1 | Extract stream byte valid |
| ext_in_data | input | 8 | Extract stream byte |
| ext_in_last | input | 1 | Last byte of the incoming frame |
| ext_in_ready | output | 1 | Extract store can accept a byte |
| ins_out_valid | output | 1 | Insert stream byte valid |
| ins_out_data | output | 8 | Insert stream byte |
| ins_out_last | output | 1 | Last byte of the outgoing frame |
| ins_out_ready | input | 1 | Datapath accepts the insert byte |

## Verification
The assertions assume that the datapath never sends a frame longer than EXT_DEPTH bytes. They also assume that the host raises a read strobe and a write strobe in separate cycles, and that it programs a length no larger than INS_DEPTH before it commits. The bench issues one register access at a time, with an idle cycle between accesses. It streams extract frames of at most the ring depth and keeps every programmed insert length within the insert ring. The bench drives the datapath-side handshakes only through its own tasks, so the insert output is never stalled in a way that would break the hold rule.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
  localparam int unsigned HOST_AW = 3;
  localparam int unsigned HOST_DW = 8;
  localparam int unsigned PROG_LW = 16;

  typedef enum logic [HOST_AW-1:0] {
    RA_SEL    = 3'd0,
    RA_STAT   = 3'd1,
    RA_EVENT  = 3'd2,
    RA_IRQEN  = 3'd3,
    RA_LEN_LO = 3'd4,
    RA_LEN_HI = 3'd5,
    RA_DATA   = 3'd6,
    RA_DONE   = 3'd7
  } reg_addr_e;

  localparam int unsigned ST_AVAIL     = 0;
  localparam int unsigned ST_INS_EMPTY = 1;
  localparam int unsigned EV_ARRIVE    = 0;
  localparam int unsigned EV_DROP      = 1;
  localparam int unsigned DN_RELEASE   = 0;
  localparam int unsigned DN_COMMIT    = 1;
endpackage

// File: rtl/hfp_byte_ram.sv
module hfp_byte_ram #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/hfp_len_fifo.sv
module hfp_len_fifo #(
  parameter int W     = 6,
  parameter int SLOTS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_len,
  input  logic         pop,
  output logic [W-1:0] head_len,
  output logic         empty,
  output logic         full
);
  localparam int SAW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CW  = SAW + 1;

  logic [W-1:0]   slot [SLOTS];
  logic [SAW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0]  cnt_q, cnt_n;

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(SLOTS));
  assign head_len = slot[rp_q];

  function automatic logic [SAW-1:0] bump(input logic [SAW-1:0] p);
    if (p == SAW'(SLOTS - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_comb begin
    wp_n  = push ? bump(wp_q) : wp_q;
    rp_n  = pop ? bump(rp_q) : rp_q;
    cnt_n = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk) begin
    if (push) slot[wp_q] <= push_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop))
    else $error("length queue pushed while full");

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty)
    else $error("length queue popped while empty");
endmodule

// File: rtl/hfp_extract_q.sv
module hfp_extract_q #(
  parameter int DEPTH = 32,
  parameter int SLOTS = 4,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  input  logic          rd_pop,
  output logic [7:0]    rd_data,
  input  logic          rel,
  output logic          avail,
  output logic [LW-1:0] head_len,
  output logic          frame_in
);
  logic [AW-1:0] wptr_q, wptr_n, base_q, base_n;
  logic [LW-1:0] idx_q, idx_n, occ_q, occ_n, cur_q, cur_n;
  logic          lf_empty, lf_full, in_fire, rd_ok, do_rel;
  logic [7:0]    ram_q;

  assign in_ready = (occ_q < LW'(DEPTH)) && !lf_full;
  assign in_fire  = in_valid && in_ready;
  assign frame_in = in_fire && in_last;
  assign avail    = !lf_empty;
  assign rd_ok    = avail && (idx_q < head_len);
  assign rd_data  = rd_ok ? ram_q : 8'h00;
  assign do_rel   = rel && avail;

  hfp_byte_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (in_fire),
    .waddr (wptr_q),
    .wdata (in_data),
    .raddr (base_q + idx_q[AW-1:0]),
    .rdata (ram_q)
  );

  hfp_len_fifo #(.W(LW), .SLOTS(SLOTS)) u_lens (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (frame_in),
    .push_len (cur_q + 1'b1),
    .pop      (do_rel),
    .head_len (head_len),
    .empty    (lf_empty),
    .full     (lf_full)
  );

  always_comb begin
    wptr_n = in_fire ? wptr_q + 1'b1 : wptr_q;
    cur_n  = cur_q;
    if (in_fire) cur_n = in_last ? '0 : cur_q + 1'b1;
    idx_n  = idx_q;
    base_n = base_q;
    if (do_rel) begin
      idx_n  = '0;
      base_n = base_q + head_len[AW-1:0];
    end else if (rd_pop && rd_ok) begin
      idx_n  = idx_q + 1'b1;
    end
    occ_n = occ_q + LW'(in_fire) - (do_rel ? head_len : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      base_q <= '0;
      idx_q  <= '0;
      occ_q  <= '0;
      cur_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      base_q <= base_n;
      idx_q  <= idx_n;
      occ_q  <= occ_n;
      cur_q  <= cur_n;
    end
  end

  assert_past_len_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !rd_ok && !rel) |=> $stable(idx_q))
    else $error("read position moved past frame end");

  assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    avail |-> (idx_q <= head_len))
    else $error("read position beyond head frame");

  assert_occ_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= LW'(DEPTH))
    else $error("extract store overfilled");
endmodule

// File: rtl/hfp_insert_q.sv
module hfp_insert_q #(
  parameter int DEPTH = 32,
  parameter int SLOTS = 4,
  parameter int PLW   = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = AW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_push,
  input  logic [7:0]     wr_data,
  input  logic [PLW-1:0] prog_len,
  input  logic           commit_req,
  output logic           drop_evt,
  output logic           empty,
  output logic           out_valid,
  output logic [7:0]     out_data,
  output logic           out_last,
  input  logic           out_ready
);
  logic [AW-1:0] fstart_q, fstart_n, optr_q, optr_n;
  logic [LW-1:0] cnt_q, cnt_n, occ_q, occ_n, oidx_q, oidx_n, head_len;
  logic          lf_empty, lf_full, accept, len_ok, out_fire, pop;

  assign accept   = wr_push && (PLW'(cnt_q) < prog_len) && (occ_q < LW'(DEPTH));
  assign len_ok   = commit_req && (PLW'(cnt_q) == prog_len) && (cnt_q != '0) && !lf_full;
  assign drop_evt = commit_req && !len_ok;
  assign empty    = lf_empty;
  assign out_valid = !lf_empty;
  assign out_last  = (oidx_q + 1'b1 == head_len);
  assign out_fire  = out_valid && out_ready;
  assign pop       = out_fire && out_last;

  hfp_byte_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (accept),
    .waddr (fstart_q + cnt_q[AW-1:0]),
    .wdata (wr_data),
    .raddr (optr_q),
    .rdata (out_data)
  );

  hfp_len_fifo #(.W(LW), .SLOTS(SLOTS)) u_lens (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (len_ok),
    .push_len (cnt_q),
    .pop      (pop),
    .head_len (head_len),
    .empty    (lf_empty),
    .full     (lf_full)
  );

  always_comb begin
    fstart_n = len_ok ? fstart_q + cnt_q[AW-1:0] : fstart_q;
    cnt_n    = commit_req ? '0 : cnt_q + LW'(accept);
    optr_n   = out_fire ? optr_q + 1'b1 : optr_q;
    oidx_n   = oidx_q;
    if (out_fire) oidx_n = out_last ? '0 : oidx_q + 1'b1;
    occ_n    = occ_q + LW'(accept) - LW'(out_fire) - (drop_evt ? cnt_q : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fstart_q <= '0;
      cnt_q    <= '0;
      optr_q   <= '0;
      oidx_q   <= '0;
      occ_q    <= '0;
    end else begin
      fstart_q <= fstart_n;
      cnt_q    <= cnt_n;
      optr_q   <= optr_n;
      oidx_q   <= oidx_n;
      occ_q    <= occ_n;
    end
  end

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
    else $error("insert byte changed while stalled");

  assert_cnt_within_occ_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= occ_q) && (occ_q <= LW'(DEPTH)))
    else $error("insert staging count inconsistent");
endmodule

// File: rtl/hfp_host_port.sv
module hfp_host_port
  import hfp_pkg::*;
#(
  parameter int EXT_DEPTH = 32,
  parameter int EXT_SLOTS = 4,
  parameter int INS_DEPTH = 32,
  parameter int INS_SLOTS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hwr_en,
  input  logic       hrd_en,
  input  logic [2:0] haddr,
  input  logic [7:0] hwdata,
  output logic [7:0] hrdata,
  output logic       irq,
  input  logic       ext_in_valid,
  input  logic [7:0] ext_in_data,
  input  logic       ext_in_last,
  output logic       ext_in_ready,
  output logic       ins_out_valid,
  output logic [7:0] ins_out_data,
  output logic       ins_out_last,
  input  logic       ins_out_ready
);
  localparam int EXT_AW = $clog2(EXT_DEPTH);
  localparam int EXT_LW = EXT_AW + 1;

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;

  logic              sel_q, sel_n, irqen_q, irqen_n;
  logic [1:0]        event_q, event_n, done_q, done_n;
  logic [PROG_LW-1:0] len_q, len_n;
  logic [7:0]        hrdata_q, hrdata_n, rd_mux;
  logic [PROG_LW-1:0] len_view;

  logic              ext_avail, ext_frame_in, ext_rd_pop, ext_rel;
  logic [EXT_LW-1:0] ext_head_len;
  logic [7:0]        ext_rd_byte;
  logic              ins_push, ins_commit, ins_drop, ins_empty;
  logic              wr_sel, wr_event, wr_irqen, wr_lo, wr_hi, wr_data, wr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign wr_sel   = hwr_en && (haddr == RA_SEL);
  assign wr_event = hwr_en && (haddr == RA_EVENT);
  assign wr_irqen = hwr_en && (haddr == RA_IRQEN);
  assign wr_lo    = hwr_en && (haddr == RA_LEN_LO) && sel_q;
  assign wr_hi    = hwr_en && (haddr == RA_LEN_HI) && sel_q;
  assign wr_data  = hwr_en && (haddr == RA_DATA);
  assign wr_done  = hwr_en && (haddr == RA_DONE);

  assign ext_rd_pop = hrd_en && (haddr == RA_DATA) && !sel_q;
  assign ext_rel    = wr_done && !sel_q && hwdata[DN_RELEASE] && !done_q[DN_RELEASE];
  assign ins_push   = wr_data && sel_q;
  assign ins_commit = wr_done && sel_q && hwdata[DN_COMMIT] && !done_q[DN_COMMIT];

  hfp_extract_q #(.DEPTH(EXT_DEPTH), .SLOTS(EXT_SLOTS)) u_extract (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .in_valid (ext_in_valid),
    .in_data  (ext_in_data),
    .in_last  (ext_in_last),
    .in_ready (ext_in_ready),
    .rd_pop   (ext_rd_pop),
    .rd_data  (ext_rd_byte),
    .rel      (ext_rel),
    .avail    (ext_avail),
    .head_len (ext_head_len),
    .frame_in (ext_frame_in)
  );

  hfp_insert_q #(.DEPTH(INS_DEPTH), .SLOTS(INS_SLOTS), .PLW(PROG_LW)) u_insert (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .wr_push    (ins_push),
    .wr_data    (hwdata),
    .prog_len   (len_q),
    .commit_req (ins_commit),
    .drop_evt   (ins_drop),
    .empty      (ins_empty),
    .out_valid  (ins_out_valid),
    .out_data   (ins_out_data),
    .out_last   (ins_out_last),
    .out_ready  (ins_out_ready)
  );

  assign len_view = sel_q ? len_q : (ext_avail ? PROG_LW'(ext_head_len) : '0);

  always_comb begin
    unique case (reg_addr_e'(haddr))
      RA_SEL:    rd_mux = {7'd0, sel_q};
      RA_STAT:   rd_mux = {6'd0, ins_empty, ext_avail};
      RA_EVENT:  rd_mux = {6'd0, event_q};
      RA_IRQEN:  rd_mux = {7'd0, irqen_q};
      RA_LEN_LO: rd_mux = len_view[7:0];
      RA_LEN_HI: rd_mux = len_view[15:8];
      RA_DATA:   rd_mux = sel_q ? 8'h00 : ext_rd_byte;
      RA_DONE:   rd_mux = {6'd0, done_q};
      default:   rd_mux = 8'h00;
    endcase
  end

  always_comb begin
    sel_n    = wr_sel   ? hwdata[0] : sel_q;
    irqen_n  = wr_irqen ? hwdata[0] : irqen_q;
    done_n   = wr_done  ? hwdata[1:0] : done_q;
    len_n    = len_q;
    if (wr_lo) len_n[7:0]  = hwdata;
    if (wr_hi) len_n[15:8] = hwdata;
    event_n[EV_ARRIVE] = ext_frame_in ||
                         (event_q[EV_ARRIVE] && !(wr_event && hwdata[EV_ARRIVE]));
    event_n[EV_DROP]   = ins_drop ||
                         (event_q[EV_DROP] && !(wr_event && hwdata[EV_DROP]));
    hrdata_n = hrd_en ? rd_mux : hrdata_q;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      sel_q    <= 1'b0;
      irqen_q  <= 1'b0;
      done_q   <= 2'b00;
      len_q    <= '0;
      event_q  <= 2'b00;
      hrdata_q <= 8'h00;
    end else begin
      sel_q    <= sel_n;
      irqen_q  <= irqen_n;
      done_q   <= done_n;
      len_q    <= len_n;
      event_q  <= event_n;
      hrdata_q <= hrdata_n;
    end
  end

  assign hrdata = hrdata_q;
  assign irq    = event_q[EV_ARRIVE] && irqen_q;

  assert_event_clear_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_event && hwdata[EV_ARRIVE] && !ext_frame_in) |=> !irq)
    else $error("arrival event survived its clear");

  assert_sel_gate_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (hrd_en && haddr == RA_DATA && sel_q) |=> (hrdata == 8'h00))
    else $error("extract data leaked with insert selected");
endmodule

// File: tb/hfp_host_port_bench.sv
module hfp_host_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // each entry: {length, seed}
  localparam logic [15:0] VECS [NVEC] = '{16'h0110, 16'h0523, 16'h0C7E, 16'h2001, 16'h07C4, 16'h02F0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic hwr_en = 0, hrd_en = 0, ext_in_valid = 0, ext_in_last = 0, ins_out_ready = 0;
  logic [2:0] haddr = 0;
  logic [7:0] hwdata = 0, ext_in_data = 0;
  logic [7:0] hrdata, ins_out_data;
  logic irq, ext_in_ready, ins_out_valid, ins_out_last;
  int n_run = 0, n_fail = 0;

  hfp_host_port u_hfp_host_port (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input logic [7:0] s, input int i);
    return s + 8'(i * 3);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); hwr_en = 1; haddr = a; hwdata = d;
    @(negedge clk); hwr_en = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); hrd_en = 1; haddr = a;
    @(negedge clk); hrd_en = 0; d = hrdata;
  endtask

  task automatic push_frame(input int len, input logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      ext_in_valid = 1; ext_in_data = pat(seed, i); ext_in_last = (i == len - 1);
      while (!ext_in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk); ext_in_valid = 0; ext_in_last = 0;
  endtask

  task automatic release_head();
    bus_wr(3'd7, 8'h00); bus_wr(3'd7, 8'h01);
  endtask

  task automatic commit_ins();
    bus_wr(3'd7, 8'h00); bus_wr(3'd7, 8'h02);
  endtask

  task automatic collect(input int len, input logic [7:0] seed, input string tag);
    @(negedge clk); ins_out_ready = 1;
    for (int i = 0; i < len; i++) begin
      while (!ins_out_valid) @(negedge clk);
      chk({tag, " byte"}, ins_out_data, pat(seed, i));
      chk({tag, " last"}, ins_out_last, (i == len - 1));
      @(negedge clk);
    end
    ins_out_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d, lo, hi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 ext_in_ready", ext_in_ready, 1);
    chk("R1 ins_out_valid", ins_out_valid, 0);
    bus_rd(3'd1, d); chk("R1 STAT", d, 8'h02);
    bus_rd(3'd0, d); chk("R1 SEL", d, 0);

    // R3 empty store: data and length read zero
    bus_rd(3'd6, d); chk("R3 data with no frame", d, 0);
    bus_rd(3'd4, d); chk("R3 length with no frame", d, 0);

    // vector table: extract frames, R2 R3 R4 R8
    for (int v = 0; v < NVEC; v++) begin
      int L; logic [7:0] s;
      L = int'(VECS[v][15:8]); s = VECS[v][7:0];
      push_frame(L, s);
      bus_rd(3'd1, d); chk("R8 avail set", d[0], 1);
      bus_rd(3'd4, lo); bus_rd(3'd5, hi);
      chk("R2 length", {hi, lo}, L);
      for (int i = 0; i < L; i++) begin
        bus_rd(3'd6, d); chk("R2 byte order", d, pat(s, i));
      end
      bus_rd(3'd6, d); chk("R3 read past end", d, 0);
      bus_rd(3'd6, d); chk("R3 read past end again", d, 0);
      release_head();
      bus_rd(3'd1, d); chk("R8 avail clear after release", d[0], 0);
      bus_wr(3'd2, 8'h01);
    end

    // R9 event and interrupt; R4 queued frames
    push_frame(3, 8'h50);
    push_frame(4, 8'h90);
    bus_rd(3'd2, d); chk("R9 arrival event set", d[0], 1);
    chk("R9 irq masked", irq, 0);
    bus_wr(3'd3, 8'h01);
    chk("R9 irq enabled", irq, 1);
    bus_wr(3'd2, 8'h01);
    chk("R9 irq after clear", irq, 0);
    bus_rd(3'd2, d); chk("R9 event cleared", d[0], 0);

    // R5 data read with insert selected does not consume
    bus_wr(3'd0, 8'h01);
    bus_rd(3'd6, d); chk("R5 data read with insert selected", d, 0);
    bus_wr(3'd4, 8'h00);
    bus_wr(3'd0, 8'h00);
    bus_wr(3'd4, 8'h09);
    bus_rd(3'd4, d); chk("R5 length write ignored for extract", d, 3);
    bus_rd(3'd6, d); chk("R5 first byte intact", d, pat(8'h50, 0));
    release_head();
    bus_rd(3'd4, d); chk("R4 next frame length", d, 4);
    bus_rd(3'd6, d); chk("R4 next frame first byte", d, pat(8'h90, 0));
    bus_wr(3'd7, 8'h01);
    bus_rd(3'd4, d); chk("R4 no release without rising edge", d, 4);
    bus_rd(3'd6, d); chk("R4 position kept", d, pat(8'h90, 1));
    release_head();
    bus_rd(3'd1, d); chk("R4 store empty", d[0], 0);
    bus_wr(3'd2, 8'h01);
    bus_wr(3'd3, 8'h00);

    // R10 backpressure on frame slots and on bytes
    for (int k = 0; k < 4; k++) push_frame(1, 8'(k));
    chk("R10 ready low on full slots", ext_in_ready, 0);
    for (int k = 0; k < 4; k++) begin
      bus_rd(3'd6, d); chk("R10 slot frame byte", d, k);
      release_head();
    end
    chk("R10 ready back", ext_in_ready, 1);
    push_frame(32, 8'h33);
    chk("R10 ready low on full bytes", ext_in_ready, 0);
    release_head();
    chk("R10 ready after byte drain", ext_in_ready, 1);

    // R5 data writes ignored with extract selected; R6 insert
    bus_wr(3'd6, 8'hEE); bus_wr(3'd6, 8'hEE);
    bus_wr(3'd0, 8'h01);
    bus_wr(3'd4, 8'd2); bus_wr(3'd5, 8'd0);
    for (int i = 0; i < 2; i++) bus_wr(3'd6, pat(8'h40, i));
    commit_ins();
    collect(2, 8'h40, "R5 R6 short insert");

    // R6 commit of 5 bytes, R7 extra write ignored
    bus_wr(3'd4, 8'd5);
    for (int i = 0; i < 6; i++) bus_wr(3'd6, pat(8'hA0, i));
    commit_ins();
    bus_rd(3'd1, d); chk("R8 insert not empty", d[1], 0);
    chk("R6 output waiting", ins_out_valid, 1);
    collect(5, 8'hA0, "R6 insert");
    @(negedge clk);
    chk("R7 no sixth byte", ins_out_valid, 0);
    bus_rd(3'd1, d); chk("R8 insert empty", d[1], 1);

    // R7 short commit drops
    bus_wr(3'd4, 8'd4);
    bus_wr(3'd6, 8'h11); bus_wr(3'd6, 8'h22);
    commit_ins();
    chk("R7 dropped frame not sent", ins_out_valid, 0);
    bus_rd(3'd2, d); chk("R7 drop event", d[1], 1);
    bus_wr(3'd2, 8'h02);
    bus_rd(3'd2, d); chk("R7 drop event cleared", d[1], 0);
    bus_wr(3'd4, 8'd3);
    for (int i = 0; i < 3; i++) bus_wr(3'd6, pat(8'h07, i));
    commit_ins();
    collect(3, 8'h07, "R7 insert after drop");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule